// File: doc/BRIEF.md
# Ethernet Transmit FCS Appender

This stage sits on the transmit path between a client packet stream and the MAC datapath. It computes the 32-bit Ethernet frame check sequence over every byte the client sends for a frame and places those four bytes immediately after the last client byte. The client stream is 64 bits wide. Byte lane 0 (bits 7:0) is the first byte on the wire. A valid/ready handshake carries each beat, along with start and end markers and an empty count. On the end beat, the empty count gives the number of unused lanes at the top of the beat.

A static `pass_thru` input chooses the mode. When it is low, the block appends the FCS; this is the default use. When it is high, the client supplies frames that already end in their FCS, and the block forwards them untouched. The client flags each MAC-generated flow-control frame with `in_fc`. Such frames always receive a computed FCS, whichever mode is selected. The block does no padding, so a pass-through client must already supply frames of at least 64 bytes with the FCS counted.

When the four FCS bytes do not fit in the end beat, the block emits one additional output beat. During that cycle it drops `in_ready`. While the output is stalled, the output beat and the running checksum both stay frozen.

Top module: `eth_fcs_append`

## Requirements
- R1: The appended FCS equals the bitwise inverse of a CRC over the frame bytes. The CRC uses the generator 0x04C11DB7, is preset to all ones at the start beat, and shifts each byte in least-significant bit first.
- R2: FCS byte k (k = 0..3) is bits 8k+7:8k of the inverted register. It occupies the lane directly after the last client byte, so the x^31-order coefficient leaves first. No client byte is altered.
- R3: With `pass_thru` = 0, the input end/empty mark the last client byte. The output end/empty mark the last FCS byte, so every frame grows by exactly 4 bytes. The empty value is the number of unused top lanes on the end beat and is 0 on every other output beat.
- R4: If the end beat holds 5 to 8 client bytes (input empty 0..3) and an FCS is being appended, the output takes one more beat than the input. That extra beat carries end set and start clear. `in_ready` is low in the cycle after the end beat is accepted.
- R5: With `pass_thru` = 1 and `in_fc` = 0, the bytes, byte count and beat count are forwarded unchanged. A frame shorter than 64 bytes is not padded.
- R6: A frame whose start beat has `in_fc` = 1 gets an FCS appended as in R1 to R4, even when `pass_thru` = 1.
- R7: After reset, `out_valid` is 0 and `in_ready` is 1.
- R8: While `out_valid` = 1 and `out_ready` = 0, the output data and markers stay unchanged and `in_ready` is 0. A frame sent under random backpressure yields the same bytes and FCS as without it.
- R9: Running the R1 CRC without the final inversion over an output frame that includes its appended FCS leaves the residue 0xDEBB20E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pass_thru | input | 1 | 1 = client supplies the FCS, 0 = append it |
| in_data | input | 64 | Client beat, lane 0 first on the wire |
| in_valid | input | 1 | Client beat valid |
| in_ready | output | 1 | Stage accepts the client beat |
| in_sop | input | 1 | First beat of a frame |
| in_eop | input | 1 | Last beat of a frame |
| in_empty | input | 3 | Unused top lanes on the end beat |
| in_fc | input | 1 | Frame is a flow-control frame; sampled on the start beat |
| out_data | output | 64 | Beat toward the MAC |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sop | output | 1 | First output beat of a frame |
| out_eop | output | 1 | Last output beat of a frame |
| out_empty | output | 3 | Unused top lanes on the output end beat |

## Verification
A wrong value in the running checksum register stays hidden until the end beat of the frame it affects. It then shows as four wrong trailing bytes and a failed residue in that same frame. It does not carry into the next frame, because the start beat presets the register. A wrong split decision or pending-beat state shows as a frame one beat too short or too long, or as a stray pulse on `in_ready`, within one cycle of the end beat. The bench covers every end-beat fill from 1 to 8 bytes so that each path of the split logic appears at the ports.

// File: rtl/eth_fcs_append.sv
module eth_fcs_append #(
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pass_thru,
  input  logic [DATA_W-1:0]           in_data,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        in_sop,
  input  logic                        in_eop,
  input  logic [$clog2(DATA_W/8)-1:0] in_empty,
  input  logic                        in_fc,
  output logic [DATA_W-1:0]           out_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic                        out_sop,
  output logic                        out_eop,
  output logic [$clog2(DATA_W/8)-1:0] out_empty
);
  localparam int LANES   = DATA_W / 8;
  localparam int EMPTY_W = $clog2(LANES);
  localparam int FCS_B   = 4;
  localparam int EXT_W   = DATA_W + 8 * FCS_B;
  localparam logic [31:0] GEN = 32'h04C11DB7;

  function automatic logic [31:0] mirror32(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = v[31-b];
    return r;
  endfunction

  localparam logic [31:0] GEN_R = mirror32(GEN);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ GEN_R) : (r >> 1);
    return r;
  endfunction

  logic [31:0]        crc_r, crc_nx, fcs;
  logic               ins_r, ins_cur;
  logic               pend;
  logic [31:0]        pend_bytes;
  logic [EMPTY_W-1:0] pend_empty;
  logic [EMPTY_W:0]   n_in;
  int                 n_int;
  logic [EXT_W-1:0]   ext;
  logic               accept, free, split;

  assign n_in     = in_eop ? ((EMPTY_W+1)'(LANES) - {1'b0, in_empty}) : (EMPTY_W+1)'(LANES);
  assign n_int    = int'(n_in);
  assign free     = !out_valid || out_ready;
  assign in_ready = !pend && free;
  assign accept   = in_valid && in_ready;
  assign ins_cur  = in_sop ? (!pass_thru || in_fc) : ins_r;
  assign split    = n_int > LANES - FCS_B;
  assign fcs      = ~crc_nx;

  always_comb begin
    crc_nx = in_sop ? 32'hFFFF_FFFF : crc_r;
    for (int i = 0; i < LANES; i++)
      if (i < n_int) crc_nx = crc_step(crc_nx, in_data[8*i +: 8]);
  end

  always_comb begin
    ext = '0;
    for (int i = 0; i < LANES; i++)
      if (i < n_int) ext[8*i +: 8] = in_data[8*i +: 8];
    for (int k = 0; k < FCS_B; k++)
      ext[8*(n_int+k) +: 8] = fcs[8*k +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_r      <= '1;
      ins_r      <= 1'b0;
      pend       <= 1'b0;
      pend_bytes <= '0;
      pend_empty <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_empty  <= '0;
    end else begin
      if (accept) begin
        crc_r <= crc_nx;
        ins_r <= ins_cur;
      end
      if (free) begin
        if (pend) begin
          out_valid <= 1'b1;
          out_data  <= {{(DATA_W-32){1'b0}}, pend_bytes};
          out_sop   <= 1'b0;
          out_eop   <= 1'b1;
          out_empty <= pend_empty;
          pend      <= 1'b0;
        end else if (accept) begin
          out_valid <= 1'b1;
          out_sop   <= in_sop;
          if (in_eop && ins_cur) begin
            out_data <= ext[DATA_W-1:0];
            if (split) begin
              out_eop    <= 1'b0;
              out_empty  <= '0;
              pend       <= 1'b1;
              pend_bytes <= ext[DATA_W +: 32];
              pend_empty <= EMPTY_W'(2*LANES - FCS_B - n_int);
            end else begin
              out_eop   <= 1'b1;
              out_empty <= EMPTY_W'(LANES - FCS_B - n_int);
            end
          end else begin
            out_data  <= in_data;
            out_eop   <= in_eop;
            out_empty <= in_eop ? in_empty : '0;
          end
        end else begin
          out_valid <= 1'b0;
        end
      end
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                   && $stable(out_eop) && $stable(out_empty)));

  a_r8_no_take_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r4_extra_beat_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && pend) |=> (out_valid && out_eop && !out_sop));

  a_r4_split_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> (out_valid && !out_eop));

  a_r3_empty_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eop) |-> (out_empty == '0));

  a_r8_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(crc_r));
endmodule

// File: tb/eth_fcs_append_tb.sv
module eth_fcs_append_tb_top;
  localparam int LANES = 8;
  localparam int NV    = 15;
  // bit15 pass_thru, bit14 flow-control, bit13 random backpressure, [10:0] length
  localparam logic [15:0] VEC [NV] = '{
    16'h003C, 16'h003D, 16'h003E, 16'h003F, 16'h0040, 16'h0041, 16'h0042, 16'h0043,
    16'h0001, 16'h8040, 16'h8014, 16'hC044, 16'hC009, 16'h2064, 16'hA048};

  logic clk = 0, rst_n = 0, pass_thru = 0;
  logic [63:0] in_data = '0, out_data;
  logic in_valid = 0, in_ready, in_sop = 0, in_eop = 0, in_fc = 0;
  logic [2:0] in_empty = '0, out_empty;
  logic out_valid, out_ready = 1, out_sop, out_eop;

  int errors = 0, checks = 0, or_mode = 0;
  logic [7:0] rx [2048];
  logic [7:0] ex [2048];
  int rx_n = 0, rx_beats = 0, sop_seen = 0;
  bit rx_done = 0;

  always #5 clk = ~clk;

  eth_fcs_append dut_i (
    .clk(clk), .rst_n(rst_n), .pass_thru(pass_thru),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_fc(in_fc),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty));

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      if (r[0]) r = (r >> 1) ^ 32'hEDB8_8320;
      else      r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] gen_byte(input int f, input int i);
    return 8'(f * 53 + i * 29 + (i >> 3) + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (or_mode == 0) out_ready <= 1'b1;
    else if (or_mode == 1) out_ready <= ($urandom % 3) != 0;
    else out_ready <= 1'b0;
  end

  always @(negedge clk) begin
    int nb;
    #2;
    if (rst_n && out_valid && out_ready) begin
      nb = out_eop ? LANES - int'(out_empty) : LANES;
      if (out_sop) sop_seen++;
      for (int k = 0; k < nb; k++) begin
        rx[rx_n] = out_data[8*k +: 8];
        rx_n++;
      end
      rx_beats++;
      if (out_eop) rx_done = 1;
    end
  end

  task automatic clear_rx();
    rx_n = 0; rx_beats = 0; sop_seen = 0; rx_done = 0;
  endtask

  task automatic send_frame(input int f, input int len, input bit fc);
    for (int b = 0; b < len; b += LANES) begin
      @(negedge clk);
      in_valid = 1; in_sop = (b == 0); in_eop = (b + LANES >= len); in_fc = fc;
      in_empty = in_eop ? 3'(b + LANES - len) : 3'd0;
      for (int k = 0; k < LANES; k++)
        in_data[8*k +: 8] = (b + k < len) ? gen_byte(f, b + k) : 8'hEE;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; in_fc = 0;
  endtask

  task automatic wait_done();
    while (!rx_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_frame(input int f, input int len, input bit pt, input bit fc, input bit bp);
    bit ins;
    int en, bad, first;
    logic [31:0] c, fcs;
    ins = !pt || fc;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      ex[i] = gen_byte(f, i);
      c = ref_crc(c, ex[i]);
    end
    fcs = ~c;
    en = len;
    if (ins) begin
      for (int k = 0; k < 4; k++) ex[len + k] = fcs[8*k +: 8];
      en = len + 4;
    end
    chk(rx_n == en, ins ? "R3" : "R5", "byte count", 64'(rx_n), 64'(en));
    chk(rx_beats == (en + LANES - 1) / LANES, "R4", "beat count", 64'(rx_beats),
        64'((en + LANES - 1) / LANES));
    chk(sop_seen == 1, "R3", "start marker count", 64'(sop_seen), 64'd1);
    bad = 0; first = -1;
    for (int i = 0; i < len && i < rx_n; i++)
      if (rx[i] !== ex[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, bp ? "R8" : (fc ? "R6" : (pt ? "R5" : "R2")), "client byte mismatch count",
        64'(bad), 64'd0);
    if (ins && rx_n == en) begin
      chk({rx[len+3], rx[len+2], rx[len+1], rx[len]} == fcs, fc ? "R6" : "R1", "appended FCS",
          {32'h0, rx[len+3], rx[len+2], rx[len+1], rx[len]}, {32'h0, fcs});
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < rx_n; i++) c = ref_crc(c, rx[i]);
      chk(c == 32'hDEBB_20E3, "R9", "residue", {32'h0, c}, 64'hDEBB_20E3);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d0;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 0, "R7", "out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1, "R7", "in_ready after reset", 64'(in_ready), 64'd1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      pass_thru = VEC[v][15];
      or_mode = VEC[v][13] ? 1 : 0;
      clear_rx();
      send_frame(v, int'(VEC[v][10:0]), VEC[v][14]);
      wait_done();
      or_mode = 0;
      check_frame(v, int'(VEC[v][10:0]), VEC[v][15], VEC[v][14], VEC[v][13]);
    end

    // R4: full end beat in insertion mode forces an extra beat and one ready-low cycle
    pass_thru = 0; or_mode = 0; clear_rx();
    @(negedge clk);
    in_valid = 1; in_sop = 1; in_eop = 1; in_empty = 0; in_fc = 0;
    for (int k = 0; k < LANES; k++) in_data[8*k +: 8] = gen_byte(40, k);
    #1;
    chk(in_ready == 1, "R4", "ready before end beat", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
    #1;
    chk(in_ready == 0, "R4", "ready in extra-beat cycle", 64'(in_ready), 64'd0);
    @(negedge clk);
    #1;
    chk(in_ready == 1, "R4", "ready after extra beat", 64'(in_ready), 64'd1);
    wait_done();
    check_frame(40, 8, 0, 0, 0);

    // R8: output held stable while stalled
    or_mode = 2; clear_rx();
    repeat (2) @(negedge clk);
    fork
      send_frame(41, 24, 0);
    join_none
    repeat (3) @(negedge clk);
    #3;
    d0 = out_data;
    chk(out_valid == 1, "R8", "valid under stall", 64'(out_valid), 64'd1);
    repeat (3) @(negedge clk);
    #3;
    chk(out_data == d0 && out_valid, "R8", "data stable under stall", out_data, d0);
    chk(in_ready == 0, "R8", "ready low under stall", 64'(in_ready), 64'd0);
    or_mode = 0;
    wait fork;
    wait_done();
    check_frame(41, 24, 0, 0, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule